// File: doc/BRIEF.md
# Periodic Interval Timer

A register-mapped timer that produces a steady periodic event from the system clock. A fixed divide-by-sixteen stage paces a 20-bit interval counter. The interval counter climbs from zero to a programmable limit and then returns to zero. Each return to zero is a wrap. Every wrap sets a pending flag, can raise an interrupt, and adds one to a 12-bit count of elapsed periods. Software reads the counters through a simple 32-bit register bus.

There are two ways to read the counters. The acknowledging view returns the period count and the live counter value, then clears the pending flag and the period count. The image view returns the same fields and changes nothing. Software can therefore sample time freely and acknowledge only when it services the event. Clearing the enable does not stop the counter at once. The counter finishes the period in progress and parks at zero.

Top module: `pit_timer`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is low.
- R2: While the timer runs, the interval counter steps by one every 16 clocks. After an enable is written from the stopped state, the first step lands on the 16th rising edge after the write edge.
- R3: The counter runs 0, 1, … up to the limit and then returns to 0, so one period is (limit + 1) × 16 clocks. If the counter is already at or above a newly written limit, the next step returns it to 0.
- R4: Offset 0x04 reads the pending flag in bit 0, with all other bits 0. The flag is set on every wrap.
- R5: Offset 0x00 is the mode register. Bits 19:0 hold the limit, bit 24 is the run enable and bit 25 is the interrupt enable. It reads back these fields, and every other bit reads 0.
- R6: Offset 0x08 returns the period count in bits 31:20 and the counter in bits 19:0. The read clears the flag and the period count. If a wrap falls on the same edge as this read, the flag stays set and the period count becomes 1.
- R7: Offset 0x0C returns the same fields as 0x08 and has no effect on the flag or the period count.
- R8: After the run enable is cleared, the counter keeps stepping until it reaches 0 and then holds there. A wrap in this phase sets the flag and counts like any other. If the counter is already 0, it stops at once.
- R9: `irq` is high exactly when the flag is set and the interrupt enable is 1. Masking the interrupt does not stop counting or period accumulation.
- R10: The period count saturates at 4095 rather than wrapping.
- R11: The divide-by-16 stage is held at zero while the timer is stopped, so a restart always takes a full 16 clocks to the first step.
- R12: `bus_rdata` shows the addressed register in the same cycle that `bus_re` is high. Side effects take place at the closing clock edge. Unmapped offsets read 0, and `bus_rdata` is 0 while `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; an 0x08 read acknowledges |
| bus_rdata | output | 32 | Read data, valid while `bus_re` is high |
| irq | output | 1 | Interrupt request, level |

## Verification
The tightest collision is a wrap and an acknowledging read landing on the same clock edge: one function sets the flag and bumps the count, the other clears them. The bench places an 0x08 read so that its closing edge is exactly the wrap edge of a period. It then judges the result from the flag and the image view, which must show the flag still set and a period count of 1. A behavioural model runs alongside and is compared on every clock. This also covers the related overlap of a new limit being written on a stepping edge.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int DATA_W   = 32;
    localparam int CNT_W    = 20;
    localparam int PCNT_W   = 12;
    localparam int PCNT_LSB = DATA_W - PCNT_W;
    localparam int EN_BIT   = 24;
    localparam int IEN_BIT  = 25;

    localparam logic [DATA_W-1:0] OFS_MODE  = 32'h00;
    localparam logic [DATA_W-1:0] OFS_FLAG  = 32'h04;
    localparam logic [DATA_W-1:0] OFS_VALUE = 32'h08;
    localparam logic [DATA_W-1:0] OFS_IMAGE = 32'h0C;

    typedef struct packed {
        logic             ien;
        logic             en;
        logic [CNT_W-1:0] limit;
    } mode_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_FLAG,
        SEL_VALUE,
        SEL_IMAGE
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [DATA_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_MODE:  s = SEL_MODE;
            OFS_FLAG:  s = SEL_FLAG;
            OFS_VALUE: s = SEL_VALUE;
            OFS_IMAGE: s = SEL_IMAGE;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_mode(input mode_t m);
        logic [DATA_W-1:0] r;
        r             = '0;
        r[CNT_W-1:0]  = m.limit;
        r[EN_BIT]     = m.en;
        r[IEN_BIT]    = m.ien;
        return r;
    endfunction

    function automatic mode_t unpack_mode(input logic [DATA_W-1:0] w);
        mode_t m;
        m.limit = w[CNT_W-1:0];
        m.en    = w[EN_BIT];
        m.ien   = w[IEN_BIT];
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] pack_count(input logic [PCNT_W-1:0] p,
                                                     input logic [CNT_W-1:0]  c);
        logic [DATA_W-1:0] r;
        r                            = '0;
        r[CNT_W-1:0]                 = c;
        r[PCNT_LSB +: PCNT_W]        = p;
        return r;
    endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);
    localparam bit POW2 = ((DIV & (DIV - 1)) == 0);

    logic [PW-1:0] phase;
    logic [PW-1:0] phase_nx;

    generate
        if (POW2) begin : g_pow2
            assign phase_nx = phase + 1'b1;
        end else begin : g_mod
            assign phase_nx = (phase == LAST) ? '0 : phase + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (!run) begin
            phase <= '0;
        end else begin
            phase <= phase_nx;
        end
    end

    assign tick = run && (phase == LAST);

endmodule

// File: rtl/pit_interval.sv
module pit_interval import pit_pkg::*; #(
    parameter int CW = CNT_W,
    parameter int PW = PCNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          en,
    input  logic [CW-1:0] limit,
    input  logic          ack,
    output logic          run,
    output logic [CW-1:0] cnt,
    output logic [PW-1:0] pcnt,
    output logic          status
);
    localparam logic [PW-1:0] PCNT_MAX = '1;
    localparam logic [PW-1:0] PCNT_ONE = PW'(1);

    logic wrap;

    assign run  = en || (cnt != '0);
    assign wrap = tick && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
        end else if (wrap) begin
            status <= 1'b1;
        end else if (ack) begin
            status <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (ack) begin
            pcnt <= wrap ? PCNT_ONE : '0;
        end else if (wrap && (pcnt != PCNT_MAX)) begin
            pcnt <= pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/pit_regs.sv
module pit_regs import pit_pkg::*; #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [PCNT_W-1:0] pcnt,
    input  logic              status,
    output mode_t             mode_q,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] addr_ext;
    reg_sel_e          sel;
    logic              unused_wbits;

    assign addr_ext     = DATA_W'(addr);
    assign sel          = decode_offset(addr_ext);
    assign ack          = re && (sel == SEL_VALUE);
    assign unused_wbits = ^{wdata[DATA_W-1:IEN_BIT+1], wdata[EN_BIT-1:CNT_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (we && (sel == SEL_MODE)) begin
            mode_q <= unpack_mode(wdata);
        end
    end

    always_comb begin
        rdata = '0;
        if (re) begin
            case (sel)
                SEL_MODE:  rdata = pack_mode(mode_q);
                SEL_FLAG:  rdata = DATA_W'(status);
                SEL_VALUE: rdata = pack_count(pcnt, cnt);
                SEL_IMAGE: rdata = pack_count(pcnt, cnt);
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pit_timer.sv
module pit_timer import pit_pkg::*; #(
    parameter int PRESCALE = 16,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    mode_t             mode_q;
    logic              tick;
    logic              run;
    logic              ack;
    logic              status;
    logic [CNT_W-1:0]  cnt;
    logic [PCNT_W-1:0] pcnt;

    pit_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    pit_interval #(.CW(CNT_W), .PW(PCNT_W)) u_int (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .en     (mode_q.en),
        .limit  (mode_q.limit),
        .ack    (ack),
        .run    (run),
        .cnt    (cnt),
        .pcnt   (pcnt),
        .status (status)
    );

    pit_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .re     (bus_re),
        .cnt    (cnt),
        .pcnt   (pcnt),
        .status (status),
        .mode_q (mode_q),
        .ack    (ack),
        .rdata  (bus_rdata)
    );

    assign irq = status & mode_q.ien;

endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk import pit_pkg::*; #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_re,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  limit,
    input logic              en,
    input logic              status,
    input logic [PCNT_W-1:0] pcnt
);
    logic wrap_now;
    logic ack_now;
    logic img_now;

    assign wrap_now = tick && (cnt >= limit);
    assign ack_now  = bus_re && (bus_addr == ADDR_W'(OFS_VALUE));
    assign img_now  = bus_re && (bus_addr == ADDR_W'(OFS_IMAGE));

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> cnt == $past(cnt)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + 1'b1) || (cnt == '0))); // R3
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
        wrap_now |=> status); // R4
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ack_now && !wrap_now) |=> (!status && (pcnt == '0))); // R6
    AST_ACK_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ack_now && wrap_now) |=> (status && (pcnt == PCNT_W'(1)))); // R6
    AST_IMAGE_PURE: assert property (@(posedge clk) disable iff (rst)
        (img_now && !wrap_now) |=> ($stable(status) && $stable(pcnt))); // R7
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en && (cnt == '0)) |=> (cnt == '0)); // R8
    AST_PCNT_SAT: assert property (@(posedge clk) disable iff (rst)
        ((pcnt == '1) && !ack_now) |=> (pcnt == '1)); // R10

endmodule

bind pit_timer pit_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_re   (bus_re),
    .bus_addr (bus_addr),
    .tick     (tick),
    .cnt      (cnt),
    .limit    (mode_q.limit),
    .en       (mode_q.en),
    .status   (status),
    .pcnt     (pcnt)
);

// File: tb/pit_timer_tb.sv
module pit_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_pre = 0, m_cnt = 0, m_pcnt = 0, m_limit = 0;
    bit m_status = 0, m_en = 0, m_ien = 0;
    bit b_run, b_tick, b_wrap, b_ack;

    always #5 clk = ~clk;

    pit_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_pcnt = 0; m_limit = 0;
            m_status = 0; m_en = 0; m_ien = 0;
        end else begin
            b_run  = m_en || (m_cnt != 0);
            b_tick = b_run && (m_pre == 15);
            b_wrap = b_tick && (m_cnt >= m_limit);
            b_ack  = bus_re && (bus_addr == 8'h08);
            m_pre  = b_run ? (m_pre + 1) % 16 : 0;
            if (b_tick) m_cnt = b_wrap ? 0 : m_cnt + 1;
            if (b_ack) m_pcnt = b_wrap ? 1 : 0;
            else if (b_wrap && m_pcnt < 4095) m_pcnt = m_pcnt + 1;
            if (b_wrap) m_status = 1;
            else if (b_ack) m_status = 0;
            if (bus_we && bus_addr == 8'h00) begin
                m_limit = int'(bus_wdata[19:0]);
                m_en    = bus_wdata[24];
                m_ien   = bus_wdata[25];
            end
        end
    end

    function automatic logic [31:0] model_rd();
        logic [31:0] r;
        r = 32'h0;
        if (bus_re) begin
            case (bus_addr)
                8'h00: r = {6'b0, m_ien, m_en, 4'b0, m_limit[19:0]};
                8'h04: r = {31'b0, m_status};
                8'h08, 8'h0C: r = {m_pcnt[11:0], m_cnt[19:0]};
                default: r = 32'h0;
            endcase
        end
        return r;
    endfunction

    function automatic string addr_tag();
        if (!bus_re) return "R12";
        case (bus_addr)
            8'h00: return "R5";
            8'h04: return "R4";
            8'h08: return "R6";
            8'h0C: return "R7";
            default: return "R12";
        endcase
    endfunction

    task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            ck("R9 irq", {31'b0, irq}, {31'b0, m_status && m_ien});
            ck(addr_tag(), bus_rdata, model_rd());
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 32'h0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_re = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++; nerr++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        // R1 reset state
        do_reset();
        rd(8'h00, d); ck("R1 mode", d, 32'h0);
        rd(8'h04, d); ck("R1 flag", d, 32'h0);
        rd(8'h08, d); ck("R1 value", d, 32'h0);
        rd(8'h0C, d); ck("R1 image", d, 32'h0);
        ck("R1 irq", {31'b0, irq}, 32'h0);

        // R5 field mapping
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d); ck("R5 readback", d, 32'h030F_FFFF);

        // R2 R3 R4 R6 R7 with limit 3
        do_reset();
        wr(8'h00, 32'h0100_0003);
        wt(15);
        rd(8'h0C, d); ck("R2 before first step", d, 32'h0);
        rd(8'h0C, d); ck("R2 first step", d, 32'h1);
        wt(46);
        rd(8'h0C, d); ck("R3 at limit", d, 32'h3);
        rd(8'h04, d); ck("R4 flag on wrap", d, 32'h1);
        rd(8'h0C, d); ck("R7 image after wrap", d, 32'h0010_0000);
        rd(8'h04, d); ck("R7 flag untouched", d, 32'h1);
        rd(8'h08, d); ck("R6 value read", d, 32'h0010_0000);
        rd(8'h0C, d); ck("R6 count cleared", d, 32'h0);
        rd(8'h04, d); ck("R6 flag cleared", d, 32'h0);
        wt(57);
        rd(8'h08, d); ck("R6 value on wrap edge", d, 32'h0000_0003);
        rd(8'h04, d); ck("R6 wrap beats ack flag", d, 32'h1);
        rd(8'h0C, d); ck("R6 wrap beats ack count", d, 32'h0010_0000);

        // R9 interrupt masking
        ck("R9 masked", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'h0300_0003);
        ck("R9 unmasked", {31'b0, irq}, 32'h1);
        wr(8'h00, 32'h0100_0003);
        ck("R9 remasked", {31'b0, irq}, 32'h0);

        // R3 limit lowered below the counter
        do_reset();
        wr(8'h00, 32'h0100_0009);
        wt(63);
        wr(8'h00, 32'h0100_0001);
        wt(15);
        rd(8'h0C, d); ck("R3 above limit", d, 32'h4);
        rd(8'h0C, d); ck("R3 early wrap", d, 32'h0010_0000);

        // R8 disable mid-period, R11 restart
        do_reset();
        wr(8'h00, 32'h0100_0003);
        wt(40);
        wr(8'h00, 32'h0000_0003);
        wt(22);
        rd(8'h0C, d); ck("R8 runs on after disable", d, 32'h3);
        rd(8'h0C, d); ck("R8 final wrap counted", d, 32'h0010_0000);
        wt(40);
        rd(8'h0C, d); ck("R8 parked at zero", d, 32'h0010_0000);

        // R8 immediate stop at zero, R11 held prescaler
        do_reset();
        wr(8'h00, 32'h0100_0003);
        wt(5);
        wr(8'h00, 32'h0000_0003);
        wt(10);
        rd(8'h0C, d); ck("R8 stopped at zero", d, 32'h0);
        wr(8'h00, 32'h0100_0003);
        wt(15);
        rd(8'h0C, d); ck("R11 full delay", d, 32'h0);
        rd(8'h0C, d); ck("R11 first step", d, 32'h1);

        // R10 saturation with limit 0
        do_reset();
        wr(8'h00, 32'h0100_0000);
        wt(4100 * 16);
        rd(8'h0C, d); ck("R10 saturated", d, 32'hFFF0_0000);
        rd(8'h08, d); ck("R10 value saturated", d, 32'hFFF0_0000);

        // R12 unmapped and idle read data
        rd(8'h10, d); ck("R12 unmapped", d, 32'h0);
        rd(8'h05, d); ck("R12 unaligned", d, 32'h0);
        @(negedge clk); #1;
        ck("R12 idle bus", bus_rdata, 32'h0);

        wt(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule